// File: doc/BRIEF.md
# UART FIFO Depth and Trigger Level Controller

This block decides how deep a UART's receive and transmit FIFOs are and when each of them should raise an interrupt request. It runs in one of three modes. With the FIFO enable bit clear, the UART works one character at a time. With the enable bit set and all four extended level registers at zero, it runs in a legacy mode: the depth is 32 and the trigger levels come from 2-bit codes in the FIFO control byte. With the enable bit set and any of those four registers nonzero, it runs in an extended mode: the depth is 128 and the trigger levels come straight from two byte-wide level registers.

The block takes the register values and the live RX and TX FIFO occupancy counts. It returns registered RX and TX interrupt requests and the active depth. When the mode changes, it also produces a single-cycle flush pulse that clears both FIFOs. The FIFO storage and the host register decoding sit outside this block and feed it.

Top module: `uart_fifo_trigger_ctl`

## Requirements
- R1: The `depth` output is registered and follows its inputs one clock later. It is 128 when `fcr_val[0]` is 1 and any of `txlvl_reg`, `rxlvl_reg`, `flow_hi_reg`, `flow_lo_reg` is nonzero. It is 32 when `fcr_val[0]` is 1 and all four are zero.
- R2: In legacy mode the RX trigger level is set by `fcr_val[7:6]`: code 00 gives 8, 01 gives 16, 10 gives 24 and 11 gives 28.
- R3: In legacy mode with `enh_feat` = 1, the TX trigger level is set by `fcr_val[5:4]`: code 00 gives 16, 01 gives 8, 10 gives 24 and 11 gives 30.
- R4: In legacy mode with `enh_feat` = 0, the TX trigger level stays at 16 whatever `fcr_val[5:4]` holds.
- R5: In extended mode the RX level equals `rxlvl_reg` and the TX level equals `txlvl_reg`. A register value of 0 acts as level 1, and a value above 128 acts as level 128.
- R6: `flush` goes high for exactly one cycle in the cycle after either of two changes: `fcr_val[0]` changes, or the all-zero status of the four extended registers changes.
- R7: Changing the extended registers without changing their all-zero status, or changing the code bits of `fcr_val`, produces no flush.
- R8: `rx_irq` is registered and is 1 when `rx_count` is at or above the RX level. `tx_irq` is registered and is 1 when `tx_count` is at or below the depth minus the TX level.
- R9: With `fcr_val[0]` = 0, the depth is 1 and both levels are 1. So `rx_irq` is 1 for any nonzero `rx_count`, and `tx_irq` is 1 only when `tx_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fcr_val | input | 8 | FIFO control byte: bit 0 enables the FIFOs, [7:6] is the RX code, [5:4] is the TX code |
| enh_feat | input | 1 | Enhanced-feature enable; lets the legacy TX code take effect |
| txlvl_reg | input | 8 | Extended-mode TX trigger level register |
| rxlvl_reg | input | 8 | Extended-mode RX trigger level register |
| flow_hi_reg | input | 8 | Flow-control upper count register (used here only for mode selection) |
| flow_lo_reg | input | 8 | Flow-control lower count register (used here only for mode selection) |
| rx_count | input | 8 | Current RX FIFO occupancy |
| tx_count | input | 8 | Current TX FIFO occupancy |
| rx_irq | output | 1 | RX interrupt request |
| tx_irq | output | 1 | TX interrupt request |
| depth | output | 8 | Active FIFO depth (1, 32 or 128) |
| flush | output | 1 | One-cycle reset pulse for both FIFOs |

## Verification
The assertions assume two things about the inputs. First, the register inputs and `fcr_val[0]` are held at zero while reset is asserted, so the internal mode copy starts in agreement with the inputs and the first flush has a real cause. Second, the occupancy counts never exceed 128. The bench respects both. It drives all inputs to zero during reset, changes them only on the falling edge, and keeps every occupancy value within the depth of the mode it is testing.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_LEG = 2'd1,
    MODE_EXT = 2'd2
  } fifo_mode_e;

  // Legacy-mode RX code to level mapping
  function automatic logic [7:0] leg_rx_level(input logic [1:0] code);
    case (code)
      2'b00:   leg_rx_level = 8'd8;
      2'b01:   leg_rx_level = 8'd16;
      2'b10:   leg_rx_level = 8'd24;
      default: leg_rx_level = 8'd28;
    endcase
  endfunction

  // Legacy-mode TX code to level mapping
  function automatic logic [7:0] leg_tx_level(input logic [1:0] code);
    case (code)
      2'b00:   leg_tx_level = 8'd16;
      2'b01:   leg_tx_level = 8'd8;
      2'b10:   leg_tx_level = 8'd24;
      default: leg_tx_level = 8'd30;
    endcase
  endfunction

endpackage

// File: rtl/uft_mode_track.sv
module uft_mode_track
  import uft_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [REG_W-1:0] txl,
  input  logic [REG_W-1:0] rxl,
  input  logic [REG_W-1:0] fhi,
  input  logic [REG_W-1:0] flo,
  output fifo_mode_e       mode,
  output logic             flush_o
);

  logic ext_d, ext_q;
  logic en_q;
  logic flush_d, flush_q;

  // next-state
  always_comb begin
    ext_d   = (|txl) | (|rxl) | (|fhi) | (|flo);
    flush_d = (ext_d != ext_q) | (fifo_en != en_q);
    if (!fifo_en)   mode = MODE_OFF;
    else if (ext_d) mode = MODE_EXT;
    else            mode = MODE_LEG;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      en_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      ext_q   <= ext_d;
      en_q    <= fifo_en;
      flush_q <= flush_d;
    end
  end

  assign flush_o = flush_q;

endmodule

// File: rtl/uft_level_sel.sv
module uft_level_sel
  import uft_pkg::*;
#(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned LEG_DEPTH = 32,
  parameter int unsigned EXT_DEPTH = 128
) (
  input  fifo_mode_e       mode,
  input  logic [7:0]       fcr,
  input  logic             enh,
  input  logic [REG_W-1:0] txl,
  input  logic [REG_W-1:0] rxl,
  output logic [CNT_W-1:0] rx_lvl,
  output logic [CNT_W-1:0] tx_lvl,
  output logic [CNT_W-1:0] depth
);

  localparam int unsigned CMP_W = (REG_W > CNT_W) ? REG_W : CNT_W;
  localparam logic [CMP_W-1:0] EXT_MAX = CMP_W'(EXT_DEPTH);

  logic [CMP_W-1:0] rx_wide, tx_wide;
  logic [CNT_W-1:0] rx_ext, tx_ext;
  logic [1:0]       tx_code;

  always_comb begin
    rx_wide = CMP_W'(rxl);
    tx_wide = CMP_W'(txl);

    if (rx_wide == '0)          rx_ext = CNT_W'(1);
    else if (rx_wide > EXT_MAX) rx_ext = CNT_W'(EXT_DEPTH);
    else                        rx_ext = CNT_W'(rx_wide);

    if (tx_wide == '0)          tx_ext = CNT_W'(1);
    else if (tx_wide > EXT_MAX) tx_ext = CNT_W'(EXT_DEPTH);
    else                        tx_ext = CNT_W'(tx_wide);

    tx_code = enh ? fcr[5:4] : 2'b00;

    case (mode)
      MODE_LEG: begin
        rx_lvl = CNT_W'(leg_rx_level(fcr[7:6]));
        tx_lvl = CNT_W'(leg_tx_level(tx_code));
        depth  = CNT_W'(LEG_DEPTH);
      end
      MODE_EXT: begin
        rx_lvl = rx_ext;
        tx_lvl = tx_ext;
        depth  = CNT_W'(EXT_DEPTH);
      end
      default: begin
        rx_lvl = CNT_W'(1);
        tx_lvl = CNT_W'(1);
        depth  = CNT_W'(1);
      end
    endcase
  end

endmodule

// File: rtl/uft_req_cmp.sv
module uft_req_cmp #(
  parameter int unsigned CNT_W   = 8,
  parameter bit          TX_SIDE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] lvl,
  input  logic [CNT_W-1:0] depth,
  output logic             req
);

  logic req_d, req_q;

  generate
    if (TX_SIDE) begin : g_tx
      logic [CNT_W-1:0] room;
      always_comb begin
        room  = depth - lvl;
        req_d = (count <= room);
      end
    end else begin : g_rx
      always_comb req_d = (count >= lvl);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;

endmodule

// File: rtl/uart_fifo_trigger_ctl.sv
module uart_fifo_trigger_ctl
  import uft_pkg::*;
#(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned LEG_DEPTH = 32,
  parameter int unsigned EXT_DEPTH = 128,
  localparam int unsigned CNT_W    = $clog2(EXT_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       fcr_val,
  input  logic             enh_feat,
  input  logic [REG_W-1:0] txlvl_reg,
  input  logic [REG_W-1:0] rxlvl_reg,
  input  logic [REG_W-1:0] flow_hi_reg,
  input  logic [REG_W-1:0] flow_lo_reg,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic [CNT_W-1:0] depth,
  output logic             flush
);

  fifo_mode_e       mode;
  logic [CNT_W-1:0] rx_lvl, tx_lvl, depth_d, depth_q;

  uft_mode_track #(.REG_W(REG_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fcr_val[0]),
    .txl     (txlvl_reg),
    .rxl     (rxlvl_reg),
    .fhi     (flow_hi_reg),
    .flo     (flow_lo_reg),
    .mode    (mode),
    .flush_o (flush)
  );

  uft_level_sel #(
    .REG_W(REG_W), .CNT_W(CNT_W), .LEG_DEPTH(LEG_DEPTH), .EXT_DEPTH(EXT_DEPTH)
  ) u_lvl (
    .mode   (mode),
    .fcr    (fcr_val),
    .enh    (enh_feat),
    .txl    (txlvl_reg),
    .rxl    (rxlvl_reg),
    .rx_lvl (rx_lvl),
    .tx_lvl (tx_lvl),
    .depth  (depth_d)
  );

  uft_req_cmp #(.CNT_W(CNT_W), .TX_SIDE(1'b0)) u_rx_req (
    .clk (clk), .rst_n (rst_n), .count (rx_count),
    .lvl (rx_lvl), .depth (depth_d), .req (rx_irq)
  );

  uft_req_cmp #(.CNT_W(CNT_W), .TX_SIDE(1'b1)) u_tx_req (
    .clk (clk), .rst_n (rst_n), .count (tx_count),
    .lvl (tx_lvl), .depth (depth_d), .req (tx_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= CNT_W'(1);
    else        depth_q <= depth_d;
  end

  assign depth = depth_q;

endmodule

// File: rtl/uft_checker.sv
module uft_checker #(
  parameter int unsigned REG_W     = 8,
  parameter int unsigned LEG_DEPTH = 32,
  parameter int unsigned EXT_DEPTH = 128,
  parameter int unsigned CNT_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       fcr_val,
  input logic [REG_W-1:0] txlvl_reg,
  input logic [REG_W-1:0] rxlvl_reg,
  input logic [REG_W-1:0] flow_hi_reg,
  input logic [REG_W-1:0] flow_lo_reg,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] tx_count,
  input logic             rx_irq,
  input logic             tx_irq,
  input logic [CNT_W-1:0] depth,
  input logic             flush
);

  logic ext_now;
  assign ext_now = (txlvl_reg != '0) || (rxlvl_reg != '0) ||
                   (flow_hi_reg != '0) || (flow_lo_reg != '0);

  p_depth_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == CNT_W'(1)) || (depth == CNT_W'(LEG_DEPTH)) || (depth == CNT_W'(EXT_DEPTH)));

  p_flush_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_now != $past(ext_now)) || (fcr_val[0] != $past(fcr_val[0]))) |=> flush);

  p_flush_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (($past(ext_now) != $past(ext_now, 2)) ||
               ($past(fcr_val[0]) != $past(fcr_val[0], 2))));

  p_rx_req_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> ($past(rx_count) != '0));

  p_tx_req_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |=> tx_irq);

  p_off_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fcr_val[0] |=> (depth == CNT_W'(1)));

endmodule

bind uart_fifo_trigger_ctl uft_checker #(
  .REG_W(REG_W), .LEG_DEPTH(LEG_DEPTH), .EXT_DEPTH(EXT_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fcr_val(fcr_val), .txlvl_reg(txlvl_reg),
  .rxlvl_reg(rxlvl_reg), .flow_hi_reg(flow_hi_reg), .flow_lo_reg(flow_lo_reg),
  .rx_count(rx_count), .tx_count(tx_count), .rx_irq(rx_irq), .tx_irq(tx_irq),
  .depth(depth), .flush(flush)
);

// File: tb/tb_uart_fifo_trigger_ctl.sv
module tb_uart_fifo_trigger_ctl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] fcr_val, txlvl_reg, rxlvl_reg, flow_hi_reg, flow_lo_reg;
  logic       enh_feat;
  logic [7:0] rx_count, tx_count;
  logic       rx_irq, tx_irq, flush;
  logic [7:0] depth;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  uart_fifo_trigger_ctl dut (
    .clk(clk), .rst_n(rst_n), .fcr_val(fcr_val), .enh_feat(enh_feat),
    .txlvl_reg(txlvl_reg), .rxlvl_reg(rxlvl_reg), .flow_hi_reg(flow_hi_reg),
    .flow_lo_reg(flow_lo_reg), .rx_count(rx_count), .tx_count(tx_count),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .depth(depth), .flush(flush)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: inputs already set on the falling edge, sample at the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fcr_val = 0; enh_feat = 0; txlvl_reg = 0; rxlvl_reg = 0;
    flow_hi_reg = 0; flow_lo_reg = 0; rx_count = 0; tx_count = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset depth", depth, 1);
    chk("R8 reset rx_irq", rx_irq, 0);
    chk("R6 reset flush", flush, 0);
    rst_n = 1'b1;
    step();
    chk("R6 no flush after reset", flush, 0);
  endtask

  task automatic t_disabled();
    rx_count = 1; tx_count = 0; step();
    chk("R9 depth off", depth, 1);
    chk("R9 rx_irq count 1", rx_irq, 1);
    chk("R9 tx_irq empty", tx_irq, 1);
    rx_count = 0; tx_count = 1; step();
    chk("R9 rx_irq empty", rx_irq, 0);
    chk("R9 tx_irq count 1", tx_irq, 0);
  endtask

  task automatic t_legacy_rx();
    int lv [4] = '{8, 16, 24, 28};
    fcr_val = 8'h01; rx_count = 0; step();
    chk("R6 flush on enable", flush, 1);
    chk("R1 depth legacy", depth, 32);
    step();
    chk("R6 flush one cycle", flush, 0);
    for (int c = 0; c < 4; c++) begin
      fcr_val = 8'((c << 6) | 1); rx_count = 8'(lv[c] - 1); step();
      chk("R2 rx below level", rx_irq, 0);
      chk("R7 no flush on code change", flush, 0);
      rx_count = 8'(lv[c]); step();
      chk("R2 rx at level", rx_irq, 1);
    end
  endtask

  task automatic t_legacy_tx();
    int lv [4] = '{16, 8, 24, 30};
    enh_feat = 1'b1;
    for (int c = 0; c < 4; c++) begin
      fcr_val = 8'((c << 4) | 1); tx_count = 8'(32 - lv[c]); step();
      chk("R3 tx at room", tx_irq, 1);
      tx_count = 8'(33 - lv[c]); step();
      chk("R3 tx above room", tx_irq, 0);
    end
  endtask

  task automatic t_tx_no_enh();
    enh_feat = 1'b0; fcr_val = 8'h31; tx_count = 16; step();
    chk("R4 tx at 16 room", tx_irq, 1);
    tx_count = 17; step();
    chk("R4 tx at 17", tx_irq, 0);
    tx_count = 2; step();
    chk("R4 code ignored", tx_irq, 1);
  endtask

  task automatic t_extended();
    fcr_val = 8'h01; rxlvl_reg = 100; rx_count = 99; tx_count = 127; step();
    chk("R6 flush on extended", flush, 1);
    chk("R1 depth extended", depth, 128);
    chk("R5 rx below 100", rx_irq, 0);
    chk("R5 tx level zero acts as 1", tx_irq, 1);
    rx_count = 100; tx_count = 128; step();
    chk("R6 flush one cycle", flush, 0);
    chk("R5 rx at 100", rx_irq, 1);
    chk("R5 tx full", tx_irq, 0);
    rxlvl_reg = 50; txlvl_reg = 200; rx_count = 49; tx_count = 0; step();
    chk("R7 no flush same status", flush, 0);
    chk("R5 rx below 50", rx_irq, 0);
    chk("R5 tx clamp 128 empty", tx_irq, 1);
    tx_count = 1; step();
    chk("R5 tx clamp 128 one", tx_irq, 0);
    rxlvl_reg = 0; txlvl_reg = 0; flow_hi_reg = 9; rx_count = 1; step();
    chk("R7 no flush via flow reg", flush, 0);
    chk("R1 depth held by flow reg", depth, 128);
    chk("R5 rx zero acts as 1", rx_irq, 1);
    flow_hi_reg = 0; step();
    chk("R6 flush back to legacy", flush, 1);
    chk("R1 depth legacy again", depth, 32);
    fcr_val = 8'h00; step();
    chk("R6 flush on disable", flush, 1);
    chk("R9 depth off again", depth, 1);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_legacy_rx();
    t_legacy_tx();
    t_tx_no_enh();
    t_extended();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule